// File: doc/BRIEF.md
# Interrupt Status and Signalling Unit

This block holds a 32-bit word of pending interrupt causes and reports it to the host in two ways at once: as a level interrupt line and as a one-cycle pulse that asks for a message-signalled interrupt. Software sets cause bits by writing a mask to a raise offset. It clears them by writing a mask to an acknowledge offset. Two internal event sources, completion of a compute job and completion of a DMA transfer, post their own fixed bits. A read port returns the current word.

A mode input selects how each raise is reported. When message signalling is off, a raise that leaves the word nonzero drives the level line high. The line drops only when a clear leaves the word empty. When message signalling is on, every raise that leaves the word nonzero sends a fresh pulse, even if the bit was already set. A clear never sends a pulse.

The bus protocol, configuration space and message construction sit outside the block. It sees only a decoded write strobe with an offset and data, a read offset, the two event pulses and the mode input.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the status word reads 0, the level line is low and no pulse is given until the first raise.
- R2: A write at offset 0x60 ORs the write data into the status word, which reads back updated one cycle after the write.
- R3: A write at offset 0x64 clears every status bit that is set in the write data, leaving the other bits unchanged.
- R4: A one-cycle compute-done input sets bit 0 (0x00000001). A one-cycle DMA-done input sets bit 8 (0x00000100).
- R5: When an event input and a clear write occur in the same cycle, the clear is applied first and the event bit is then set, so the event bit survives.
- R6: With message signalling off, any raise (a write at 0x60 or an event input) that leaves the word nonzero sets the level line high one cycle later and gives no pulse.
- R7: With message signalling on, every raise that leaves the word nonzero gives a pulse exactly one cycle long one cycle later. This holds also for a bit already set and for a raise of zero data. The level line is not changed.
- R8: A clear lowers the level line only when it leaves the word zero and message signalling is off. Otherwise the line keeps its value.
- R9: A read at offset 0x24 returns the status word in the same cycle. Reads at other offsets return 0, and writes at other offsets change nothing.
- R10: A raise that leaves the word zero gives no pulse and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one per cycle |
| wr_addr | input | 8 | Write offset |
| wr_data | input | 32 | Write data (raise or clear mask) |
| rd_addr | input | 8 | Read offset |
| rd_data | output | 32 | Read data, status word at its offset, else 0 |
| compute_done | input | 1 | Compute completion event pulse |
| dma_done | input | 1 | DMA completion event pulse |
| msi_en | input | 1 | 1 selects message-signalled reporting, 0 selects the level line |
| irq_line | output | 1 | Level interrupt line |
| msi_pulse | output | 1 | One-cycle request for a message-signalled interrupt |

## Verification
The status word, the level line and the pulse are all registered. Each is due on the first clock edge after the write or event that causes it. The read data is combinational, so it shows the updated word in that same cycle. The bench drives its inputs on the falling edge and advances a behavioural model on each rising edge. On the next falling edge it compares all three outputs and the read data against the model, so every result is checked exactly in the cycle it is due. Directed checks at those same falling edges pin down the constant values behind each requirement.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int unsigned IRQ_W = 32;
  typedef logic [IRQ_W-1:0] irq_word_t;

  // Decoded request for one cycle: masks to clear and set, and event flags
  typedef struct packed {
    logic      raise_evt;
    logic      lower_evt;
    irq_word_t set_mask;
    irq_word_t clr_mask;
  } irq_req_t;
endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode
  import irq_unit_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] OFS_RAISE = 8'h60,
  parameter logic [ADDR_W-1:0] OFS_CLEAR = 8'h64,
  parameter int unsigned COMPUTE_BIT = 0,
  parameter int unsigned DMA_BIT     = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  irq_word_t         wr_data,
  input  logic              compute_done,
  input  logic              dma_done,
  output irq_req_t          req
);
  logic      sw_raise;
  logic      sw_clear;
  irq_word_t src_mask;

  assign sw_raise = wr_en && (wr_addr == OFS_RAISE);
  assign sw_clear = wr_en && (wr_addr == OFS_CLEAR);

  // Each bit position may be posted by one of the internal sources
  for (genvar g = 0; g < IRQ_W; g++) begin : g_src
    if (g == COMPUTE_BIT && g == DMA_BIT) begin : g_both
      assign src_mask[g] = compute_done | dma_done;
    end else if (g == COMPUTE_BIT) begin : g_cmp
      assign src_mask[g] = compute_done;
    end else if (g == DMA_BIT) begin : g_dma
      assign src_mask[g] = dma_done;
    end else begin : g_none
      assign src_mask[g] = 1'b0;
    end
  end

  always_comb begin
    req.raise_evt = sw_raise | compute_done | dma_done;
    req.lower_evt = sw_clear;
    req.set_mask  = (sw_raise ? wr_data : '0) | src_mask;
    req.clr_mask  = sw_clear ? wr_data : '0;
  end
endmodule

// File: rtl/irq_status_word.sv
module irq_status_word
  import irq_unit_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_req_t  req,
  output irq_word_t status_q,
  output irq_word_t cleared_w,
  output irq_word_t status_d
);
  logic upd_en;

  // Clear applies first, then the set mask is merged in
  always_comb begin
    cleared_w = status_q & ~req.clr_mask;
    status_d  = cleared_w | req.set_mask;
    upd_en    = req.raise_evt | req.lower_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (upd_en) begin
      status_q <= status_d;
    end
  end

  AST_SET_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    req.raise_evt |=> ((status_q & $past(req.set_mask)) == $past(req.set_mask))); // R2

  AST_CLEAR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    req.lower_evt |=> ((status_q & $past(req.clr_mask & ~req.set_mask)) == '0)); // R3
endmodule

// File: rtl/irq_signal_ctrl.sv
module irq_signal_ctrl
  import irq_unit_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_req_t  req,
  input  logic      msi_en,
  input  irq_word_t status_q,
  input  irq_word_t cleared_w,
  input  irq_word_t status_d,
  output logic      irq_line,
  output logic      msi_pulse
);
  logic line_d;
  logic pulse_d;
  logic line_en;

  // Lower is handled before the raise of the same cycle
  always_comb begin
    line_d  = irq_line;
    pulse_d = 1'b0;
    if (req.lower_evt && !msi_en && (cleared_w == '0)) begin
      line_d = 1'b0;
    end
    if (req.raise_evt && (status_d != '0)) begin
      if (msi_en) begin
        pulse_d = 1'b1;
      end else begin
        line_d = 1'b1;
      end
    end
    line_en = req.raise_evt | req.lower_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_line <= 1'b0;
    end else if (line_en) begin
      irq_line <= line_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_pulse <= 1'b0;
    end else begin
      msi_pulse <= pulse_d;
    end
  end

  AST_PULSE_NEEDS_MSI: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> $past(msi_en && req.raise_evt)); // R7

  AST_PULSE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> (status_q != '0)); // R10

  AST_LINE_RISE_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_line) |-> $past(!msi_en && req.raise_evt)); // R6

  AST_LINE_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_line) |-> ((status_q == '0) && $past(!msi_en && req.lower_evt))); // R8
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_unit_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_RAISE  = 8'h60,
  parameter logic [ADDR_W-1:0] OFS_CLEAR  = 8'h64,
  parameter int unsigned COMPUTE_BIT  = 0,
  parameter int unsigned DMA_BIT      = 8,
  parameter int unsigned RST_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [IRQ_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [IRQ_W-1:0]  rd_data,
  input  logic              compute_done,
  input  logic              dma_done,
  input  logic              msi_en,
  output logic              irq_line,
  output logic              msi_pulse
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;
  irq_req_t              req;
  irq_word_t             status_q;
  irq_word_t             cleared_w;
  irq_word_t             status_d;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  irq_req_decode #(
    .ADDR_W(ADDR_W), .OFS_RAISE(OFS_RAISE), .OFS_CLEAR(OFS_CLEAR),
    .COMPUTE_BIT(COMPUTE_BIT), .DMA_BIT(DMA_BIT)
  ) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .compute_done(compute_done), .dma_done(dma_done), .req(req)
  );

  irq_status_word u_word (
    .clk(clk), .rst_n(rst_sync_n), .req(req),
    .status_q(status_q), .cleared_w(cleared_w), .status_d(status_d)
  );

  irq_signal_ctrl u_sig (
    .clk(clk), .rst_n(rst_sync_n), .req(req), .msi_en(msi_en),
    .status_q(status_q), .cleared_w(cleared_w), .status_d(status_d),
    .irq_line(irq_line), .msi_pulse(msi_pulse)
  );

  assign rd_data = (rd_addr == OFS_STATUS) ? status_q : '0;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (!irq_line && !msi_pulse && status_q == '0)); // R1
endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = 8'h24;
  logic [31:0] rd_data;
  logic        compute_done = 1'b0;
  logic        dma_done = 1'b0;
  logic        msi_en = 1'b0;
  logic        irq_line;
  logic        msi_pulse;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  logic [31:0] m_status;
  logic        m_line;
  logic        m_pulse;

  always #4 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .compute_done(compute_done), .dma_done(dma_done), .msi_en(msi_en),
    .irq_line(irq_line), .msi_pulse(msi_pulse)
  );

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status <= 0; m_line <= 0; m_pulse <= 0;
    end else begin
      logic [31:0] clr, set, mid, fin;
      bit up, down, ln;
      clr  = (wr_en && wr_addr == 8'h64) ? wr_data : 0;
      set  = (wr_en && wr_addr == 8'h60) ? wr_data : 0;
      if (compute_done) set[0] = 1'b1;
      if (dma_done) set[8] = 1'b1;
      up   = (wr_en && wr_addr == 8'h60) || compute_done || dma_done;
      down = wr_en && wr_addr == 8'h64;
      mid  = m_status & ~clr;
      fin  = mid | set;
      ln   = m_line;
      m_pulse <= 0;
      if (down && !msi_en && mid == 0) ln = 0;
      if (up && fin != 0) begin
        if (msi_en) m_pulse <= 1;
        else ln = 1;
      end
      m_line <= ln;
      if (up || down) m_status <= fin;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] exp_rd;
    exp_rd = (rd_addr == 8'h24) ? m_status : 0;
    chk({cur_req, " rd_data"}, rd_data, exp_rd);
    chk({cur_req, " irq_line"}, {31'b0, irq_line}, {31'b0, m_line});
    chk({cur_req, " msi_pulse"}, {31'b0, msi_pulse}, {31'b0, m_pulse});
  endtask

  // Compare the results of the last edge, then drive the next cycle
  task automatic step(bit en, logic [7:0] a, logic [31:0] d, bit cmp, bit dma, logic [7:0] ra);
    @(negedge clk);
    compare();
    wr_en = en; wr_addr = a; wr_data = d;
    compute_done = cmp; dma_done = dma; rd_addr = ra;
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 0, 8'h24);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 reset line", {31'b0, irq_line}, 0);
    chk("R1 reset pulse", {31'b0, msi_pulse}, 0);
    chk("R1 reset status", rd_data, 0);
    rst_n = 1'b1;
    repeat (5) idle();

    cur_req = "R2";
    step(1, 8'h60, 32'h5, 0, 0, 8'h24);
    idle();
    chk("R2 raise merge", rd_data, 32'h5);
    chk("R6 line after raise", {31'b0, irq_line}, 1);
    chk("R6 no pulse legacy", {31'b0, msi_pulse}, 0);
    step(1, 8'h60, 32'h30, 0, 0, 8'h24);
    idle();
    chk("R2 second merge", rd_data, 32'h35);

    cur_req = "R3";
    step(1, 8'h64, 32'h11, 0, 0, 8'h24);
    idle();
    chk("R3 partial clear", rd_data, 32'h24);
    chk("R8 line kept nonzero", {31'b0, irq_line}, 1);
    step(1, 8'h64, 32'h24, 0, 0, 8'h24);
    idle();
    chk("R8 line fell on empty", {31'b0, irq_line}, 0);

    cur_req = "R4";
    step(0, 8'h00, 0, 1, 0, 8'h24);
    step(0, 8'h00, 0, 0, 1, 8'h24);
    idle();
    chk("R4 event bits", rd_data, 32'h101);
    chk("R6 line from event", {31'b0, irq_line}, 1);

    cur_req = "R5";
    step(1, 8'h64, 32'h101, 0, 1, 8'h24);
    idle();
    chk("R5 clear then set", rd_data, 32'h100);
    chk("R5 line stays", {31'b0, irq_line}, 1);

    cur_req = "R8";
    msi_en = 1'b1;
    step(1, 8'h64, 32'h100, 0, 0, 8'h24);
    idle();
    chk("R8 msi clear keeps line", {31'b0, irq_line}, 1);
    chk("R8 status empty", rd_data, 0);
    msi_en = 1'b0;
    cur_req = "R10";
    step(1, 8'h60, 32'h0, 0, 0, 8'h24);
    idle();
    chk("R10 zero raise line", {31'b0, irq_line}, 1);
    cur_req = "R8";
    step(1, 8'h64, 32'h0, 0, 0, 8'h24);
    idle();
    chk("R8 empty clear legacy", {31'b0, irq_line}, 0);

    cur_req = "R10";
    msi_en = 1'b1;
    step(1, 8'h60, 32'h0, 0, 0, 8'h24);
    idle();
    chk("R10 no pulse on empty", {31'b0, msi_pulse}, 0);

    cur_req = "R7";
    step(1, 8'h60, 32'h2, 0, 0, 8'h24);
    idle();
    chk("R7 pulse on raise", {31'b0, msi_pulse}, 1);
    chk("R7 line untouched", {31'b0, irq_line}, 0);
    idle();
    chk("R7 pulse one cycle", {31'b0, msi_pulse}, 0);
    step(1, 8'h60, 32'h2, 0, 0, 8'h24);
    step(1, 8'h60, 32'h0, 0, 0, 8'h24);
    chk("R7 repeat bit pulse", {31'b0, msi_pulse}, 1);
    step(0, 8'h00, 0, 1, 0, 8'h24);
    chk("R7 zero raise pulse", {31'b0, msi_pulse}, 1);
    idle();
    chk("R7 event pulse", {31'b0, msi_pulse}, 1);
    step(1, 8'h64, 32'h3, 0, 0, 8'h24);
    idle();
    chk("R7 no pulse on clear", {31'b0, msi_pulse}, 0);
    msi_en = 1'b0;

    cur_req = "R9";
    step(1, 8'h28, 32'h55, 0, 0, 8'h20);
    step(1, 8'h24, 32'hAA, 0, 0, 8'h20);
    chk("R9 other offset reads 0", rd_data, 0);
    idle();
    chk("R9 stray writes ignored", rd_data, 0);
    chk("R9 line unchanged", {31'b0, irq_line}, 0);
    repeat (3) idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule